// File: doc/BRIEF.md
# High-Speed Lane Burst Sequencer

This block is the transmit-side controller for one source-synchronous serial data lane. Between bursts the lane rests in its low-power idle state, with both single-ended lines driven high. When a byte stream offers data, the block steps the two lines through a fixed low-power entry sequence. It then turns on the high-speed driver, sends a leader of zero bits and an eight-bit sync word, and serializes the payload one bit per clock cycle. At the end it drives a trailer and returns the lane to idle.

The byte source uses valid, ready and last signals. Because the high-speed bit stream cannot stall, ready is a one-cycle slot that recurs every eight bit periods. A source that misses a slot ends the burst. The phase lengths are parameters counted in clock cycles, one clock cycle being one serial bit period: the dwell in each low-power state, the zero-leader length and the trailer length.

Top module: `hs_lane_seq`

## Requirements
- R1: During and after reset the outputs are lp_p_lvl=1, lp_n_lvl=1, hs_drive_en=0, hs_ser=0, byte_ready=0, and they stay so until byte_valid is seen high in idle.
- R2: A burst starts on the first clock edge in idle where byte_valid=1. The lines then show lp_p_lvl=0, lp_n_lvl=1 for exactly T_LPX cycles, followed by lp_p_lvl=0, lp_n_lvl=0 for exactly T_LPX cycles, with hs_drive_en=0 throughout.
- R3: While hs_drive_en=1, both low-power levels are 0. The first T_ZERO high-speed cycles carry hs_ser=0.
- R4: The next eight high-speed cycles carry the sync word, in time order 0,0,0,1,1,1,0,1.
- R5: Each accepted byte follows immediately with no gap, taking eight cycles and sent bit 0 first, up to bit 7.
- R6: byte_ready is high for a single cycle in the final bit period of the sync word and in the final bit period of every byte not flagged last. It is low in every other cycle. A byte is taken when byte_ready and byte_valid are both high, and byte_last is sampled with it.
- R7: After the final bit of the last byte, hs_ser holds the inverse of that final bit for exactly T_TRAIL cycles.
- R8: In the cycle after the trailer, hs_drive_en=0 and both low-power levels are 1. Idle lasts at least one cycle, so a request raised during the trailer starts the next entry only from that idle cycle.
- R9: If byte_valid is low when byte_ready is high, the burst ends there, as if the byte just sent (or the sync word) had been last. The trailer then inverts that final bit; right after the sync word it is 0.
- R10: byte_data, byte_valid and byte_last have no effect on the outputs in any cycle other than an idle cycle or a ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; one cycle is one serial bit period |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_data | input | 8 | Payload byte offered by the source |
| byte_valid | input | 1 | Source has a byte (also the burst request in idle) |
| byte_last | input | 1 | Offered byte is the final one of the burst |
| byte_ready | output | 1 | One-cycle byte acceptance slot |
| lp_p_lvl | output | 1 | Low-power drive level of the positive line |
| lp_n_lvl | output | 1 | Low-power drive level of the negative line |
| hs_drive_en | output | 1 | High-speed driver enable |
| hs_ser | output | 1 | Serial high-speed bit |

## Verification
Two situations are hard to reach from the ports. The first is a source that misses its acceptance slot. The second is a new request that arrives while the trailer is still on the line. The bench computes, for every burst, the exact cycle of each ready slot from T_ZERO and the byte index. At that cycle it drives byte_valid low to force an early end, including the case with no bytes at all, where the trailer follows the sync word. It also raises byte_valid for the whole trailer, then checks that exactly one idle cycle appears before the next entry. In every cycle outside the slots it drives garbage on the data, valid and last inputs.

// File: rtl/lane_seq_pkg.sv
// Shared types and constants for the lane burst sequencer.
// Assumes one clock cycle equals one serial bit period.
package lane_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LP01,
        ST_LP00,
        ST_ZERO,
        ST_SYNC,
        ST_DATA,
        ST_TRAIL
    } lane_st_e;

    localparam int BYTE_BITS = 8;

    // Sync word stored so that shifting out bit 0 first yields 0,0,0,1,1,1,0,1.
    localparam logic [BYTE_BITS-1:0] SYNC_SHIFT_WORD = 8'hB8;

endpackage

// File: rtl/lane_phase_timer.sv
// Phase timer: a down-counter loaded at each phase entry with length-1.
// done is high in the final cycle of the phase. Assumes load_val fits W bits.
module lane_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    // Count down to zero, reloading on each phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/lane_byte_shifter.sv
// Byte serializer: parallel load, right shift, bit 0 sent first.
// Also keeps the most recently sent bit so the trailer can invert it.
// Assumes a load and a shift in the same cycle means the load wins.
module lane_byte_shifter
    import lane_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [BYTE_BITS-1:0] load_val,
    input  logic                 shift_en,
    output logic                 ser_bit,
    output logic                 sent_bit
);

    logic [BYTE_BITS-1:0] sh_q;
    logic                 sent_q;

    // Load a new word or shift the current one toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_en) begin
            sh_q <= load_val;
        end else if (shift_en) begin
            sh_q <= {1'b0, sh_q[BYTE_BITS-1:1]};
        end
    end

    // Remember the bit that went out on the line this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= 1'b0;
        end else if (shift_en) begin
            sent_q <= sh_q[0];
        end
    end

    assign ser_bit  = sh_q[0];
    assign sent_bit = sent_q;

endmodule

// File: rtl/lane_seq_fsm.sv
// Burst control state machine: walks the lane through entry, leader,
// sync, payload and trailer, and opens one byte slot per eight bits.
// Assumes T_LPX, T_ZERO and T_TRAIL are all at least 1.
module lane_seq_fsm
    import lane_seq_pkg::*;
#(
    parameter int W       = 4,
    parameter int T_LPX   = 4,
    parameter int T_ZERO  = 6,
    parameter int T_TRAIL = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         byte_valid,
    input  logic         byte_last,
    input  logic         tmr_done,
    output lane_st_e     st,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         sync_load,
    output logic         data_load,
    output logic         shift_en,
    output logic         byte_ready
);

    localparam logic [W-1:0] LPX_M1   = W'(T_LPX - 1);
    localparam logic [W-1:0] ZERO_M1  = W'(T_ZERO - 1);
    localparam logic [W-1:0] TRAIL_M1 = W'(T_TRAIL - 1);
    localparam logic [W-1:0] BYTE_M1  = W'(BYTE_BITS - 1);

    lane_st_e st_q, st_d;
    logic     cur_last_q;

    // State register and last-byte flag of the byte in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cur_last_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (data_load) begin
                cur_last_q <= byte_last;
            end
        end
    end

    // Next state, phase timer reload and byte slot decode.
    always_comb begin
        st_d       = st_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        sync_load  = 1'b0;
        data_load  = 1'b0;
        byte_ready = 1'b0;
        shift_en   = (st_q == ST_SYNC) || (st_q == ST_DATA);
        case (st_q)
            ST_IDLE: begin
                if (byte_valid) begin
                    st_d     = ST_LP01;
                    tmr_load = 1'b1;
                    tmr_val  = LPX_M1;
                end
            end
            ST_LP01: begin
                if (tmr_done) begin
                    st_d     = ST_LP00;
                    tmr_load = 1'b1;
                    tmr_val  = LPX_M1;
                end
            end
            ST_LP00: begin
                if (tmr_done) begin
                    st_d     = ST_ZERO;
                    tmr_load = 1'b1;
                    tmr_val  = ZERO_M1;
                end
            end
            ST_ZERO: begin
                if (tmr_done) begin
                    st_d      = ST_SYNC;
                    tmr_load  = 1'b1;
                    tmr_val   = BYTE_M1;
                    sync_load = 1'b1;
                end
            end
            ST_SYNC, ST_DATA: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (st_q == ST_DATA && cur_last_q) begin
                        st_d    = ST_TRAIL;
                        tmr_val = TRAIL_M1;
                    end else begin
                        byte_ready = 1'b1;
                        if (byte_valid) begin
                            st_d      = ST_DATA;
                            tmr_val   = BYTE_M1;
                            data_load = 1'b1;
                        end else begin
                            st_d    = ST_TRAIL;
                            tmr_val = TRAIL_M1;
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (tmr_done) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign st = st_q;

endmodule

// File: rtl/hs_lane_seq.sv
// Top of the lane burst sequencer. Decodes line levels and the serial bit
// from the control state. Assumes the phase parameters are at least 1.
module hs_lane_seq
    import lane_seq_pkg::*;
#(
    parameter int T_LPX   = 4,
    parameter int T_ZERO  = 6,
    parameter int T_TRAIL = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] byte_data,
    input  logic       byte_valid,
    input  logic       byte_last,
    output logic       byte_ready,
    output logic       lp_p_lvl,
    output logic       lp_n_lvl,
    output logic       hs_drive_en,
    output logic       hs_ser
);

    localparam int MAX_A = (T_LPX > T_ZERO) ? T_LPX : T_ZERO;
    localparam int MAX_B = (MAX_A > T_TRAIL) ? MAX_A : T_TRAIL;
    localparam int MAX_P = (MAX_B > BYTE_BITS) ? MAX_B : BYTE_BITS;
    localparam int W     = $clog2(MAX_P + 1);

    lane_st_e     st;
    logic         tmr_load, tmr_done, sync_load, data_load, shift_en;
    logic [W-1:0] tmr_val;
    logic         sh_bit, sent_bit;

    lane_seq_fsm #(
        .W(W), .T_LPX(T_LPX), .T_ZERO(T_ZERO), .T_TRAIL(T_TRAIL)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(byte_valid), .byte_last(byte_last),
        .tmr_done(tmr_done), .st(st),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .sync_load(sync_load), .data_load(data_load),
        .shift_en(shift_en), .byte_ready(byte_ready)
    );

    lane_phase_timer #(.W(W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    lane_byte_shifter u_shf (
        .clk(clk), .rst_n(rst_n),
        .load_en(sync_load | data_load),
        .load_val(sync_load ? SYNC_SHIFT_WORD : byte_data),
        .shift_en(shift_en),
        .ser_bit(sh_bit), .sent_bit(sent_bit)
    );

    // Line level decode: idle high on both lines, entry steps, high-speed low.
    always_comb begin
        lp_p_lvl    = (st == ST_IDLE);
        lp_n_lvl    = (st == ST_IDLE) || (st == ST_LP01);
        hs_drive_en = (st == ST_ZERO) || (st == ST_SYNC) ||
                      (st == ST_DATA) || (st == ST_TRAIL);
    end

    // Serial bit select per high-speed phase.
    always_comb begin
        case (st)
            ST_SYNC, ST_DATA: hs_ser = sh_bit;
            ST_TRAIL:         hs_ser = ~sent_bit;
            default:          hs_ser = 1'b0;
        endcase
    end

endmodule

// File: rtl/hs_lane_seq_chk.sv
// Protocol checker for the lane burst sequencer, bound to the top.
// Observes only the top ports.
module hs_lane_seq_chk #(
    parameter int T_LPX = 4
) (
    input logic clk,
    input logic rst_n,
    input logic byte_ready,
    input logic lp_p_lvl,
    input logic lp_n_lvl,
    input logic hs_drive_en
);

    logic [2:0]  cur;
    logic [2:0]  last_q;
    logic [15:0] run_q;

    assign cur = {lp_p_lvl, lp_n_lvl, hs_drive_en};

    // Length of the current run of identical line states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 3'b110;
            run_q  <= 16'd1;
        end else begin
            last_q <= cur;
            if (cur == last_q) begin
                run_q <= (run_q == 16'hFFFF) ? run_q : run_q + 16'd1;
            end else begin
                run_q <= 16'd1;
            end
        end
    end

    p_lp01_dwell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur != last_q && last_q == 3'b010) |-> run_q == 16'(T_LPX));

    p_lp00_dwell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur != last_q && last_q == 3'b000) |-> run_q == 16'(T_LPX));

    p_leave_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lp_p_lvl && lp_n_lvl) && !(lp_p_lvl && lp_n_lvl)) |->
        (!lp_p_lvl && lp_n_lvl && !hs_drive_en));

    p_hs_after_lp00_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_drive_en) |-> $past(!lp_p_lvl && !lp_n_lvl));

    p_lines_low_in_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_drive_en |-> (!lp_p_lvl && !lp_n_lvl));

    p_ready_in_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> hs_drive_en);

    p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |=> !byte_ready);

    p_exit_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_drive_en) |-> (lp_p_lvl && lp_n_lvl));

endmodule

bind hs_lane_seq hs_lane_seq_chk #(.T_LPX(T_LPX)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .byte_ready(byte_ready),
    .lp_p_lvl(lp_p_lvl),
    .lp_n_lvl(lp_n_lvl),
    .hs_drive_en(hs_drive_en)
);

// File: tb/sim_hs_lane_seq.sv
// Bench: sweeps all single-byte values, multi-byte bursts, missed slots
// and requests raised during the trailer; expected waveforms computed here.
module sim_hs_lane_seq;

    localparam int CLK_PERIOD = 10;
    localparam int LPX        = 2;
    localparam int ZERO       = 3;
    localparam int TRAIL      = 4;
    localparam int WD_CYCLES  = 200000;
    localparam logic [7:0] SYNC_SEQ = 8'b1011_1000; // bit i is the i-th sent bit

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] byte_data;
    logic       byte_valid, byte_last;
    logic       byte_ready, lp_p_lvl, lp_n_lvl, hs_drive_en, hs_ser;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] bytes [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_lane_seq #(.T_LPX(LPX), .T_ZERO(ZERO), .T_TRAIL(TRAIL)) u0 (
        .clk(clk), .rst_n(rst_n),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_last(byte_last),
        .byte_ready(byte_ready), .lp_p_lvl(lp_p_lvl), .lp_n_lvl(lp_n_lvl),
        .hs_drive_en(hs_drive_en), .hs_ser(hs_ser)
    );

    // Compare {lp_p, lp_n, hs_en, hs_ser, ready} with the expectation.
    task automatic check(input logic [4:0] exp, input string req);
        logic [4:0] act;
        act = {lp_p_lvl, lp_n_lvl, hs_drive_en, hs_ser, byte_ready};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (lp_p lp_n hs_en hs_ser ready) at %0t",
                     req, act, exp, $time);
        end
    endtask

    // One burst of n bytes; uf=1 misses the slot after byte n; chain=1 raises
    // the next request during the trailer. gap = extra idle cycles first.
    task automatic run_burst(input int n, input bit uf, input int gap, input bit chain);
        int   slots, hs_len, b, k;
        logic fin, bit_e, rdy;
        string tag;
        slots  = uf ? n + 1 : n;
        hs_len = ZERO + 8 + 8 * n + TRAIL;
        fin    = (n == 0) ? SYNC_SEQ[7] : bytes[n-1][7];
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            check(5'b11000, "R1 R10");
            byte_valid = 1'b0;
            byte_data  = 8'(i * 71 + 13);
            byte_last  = i[0];
        end
        @(negedge clk);
        check(5'b11000, "R8");
        byte_valid = 1'b1;
        byte_data  = 8'h5A;
        byte_last  = 1'b1;
        for (int i = 0; i < 2 * LPX; i++) begin
            @(negedge clk);
            check((i < LPX) ? 5'b01000 : 5'b00000, "R2 R10");
            byte_valid = i[0];
            byte_data  = 8'(i * 29 + 7);
            byte_last  = ~i[0];
        end
        for (int j = 0; j < hs_len; j++) begin
            @(negedge clk);
            rdy = (j >= ZERO + 7) && (j < ZERO + 8 + 8 * n) &&
                  ((j - ZERO - 7) % 8 == 0) && ((j - ZERO - 7) / 8 < slots);
            if (j < ZERO) begin
                bit_e = 1'b0; tag = "R3";
            end else if (j < ZERO + 8) begin
                bit_e = SYNC_SEQ[j - ZERO]; tag = "R4";
            end else if (j < ZERO + 8 + 8 * n) begin
                b = j - ZERO - 8;
                bit_e = bytes[b / 8][b % 8]; tag = "R5";
            end else begin
                bit_e = ~fin; tag = uf ? "R9" : "R7";
            end
            if (rdy) tag = uf ? "R6 R9" : "R6";
            check({2'b00, 1'b1, bit_e, rdy}, tag);
            if (rdy) begin
                k = (j - ZERO - 7) / 8;
                if (k < n) begin
                    byte_valid = 1'b1;
                    byte_data  = bytes[k];
                    byte_last  = !uf && (k == n - 1);
                end else begin
                    byte_valid = 1'b0;
                    byte_data  = 8'hFF;
                    byte_last  = 1'b1;
                end
            end else begin
                byte_data = 8'(j * 29 + 7);
                byte_last = j[1];
                if (chain && j >= hs_len - TRAIL) byte_valid = 1'b1;
                else if (j == hs_len - 1)        byte_valid = 1'b0;
                else                              byte_valid = j[0];
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Main sequence.
    initial begin
        rst_n      = 1'b0;
        byte_valid = 1'b1;
        byte_data  = 8'h00;
        byte_last  = 1'b0;
        repeat (3) @(negedge clk);
        check(5'b11000, "R1");
        rst_n      = 1'b1;
        byte_valid = 1'b0;
        // Every single-byte value: payload order and trailer inversion.
        for (int v = 0; v < 256; v++) begin
            bytes[0] = 8'(v);
            run_burst(1, 1'b0, 1, 1'b0);
        end
        // Multi-byte bursts with back-to-back slots.
        for (int n = 2; n <= 6; n++) begin
            for (int k = 0; k < n; k++) bytes[k] = 8'(n * 53 + k * 37 + 11);
            run_burst(n, 1'b0, 2, 1'b0);
        end
        // Missed slots, including right after the sync word.
        for (int n = 0; n <= 3; n++) begin
            for (int k = 0; k < n; k++) bytes[k] = 8'(n * 19 + k * 101 + 3);
            run_burst(n, 1'b1, 1, 1'b0);
        end
        // Requests raised during the trailer.
        bytes[0] = 8'h81; bytes[1] = 8'h7E;
        run_burst(2, 1'b0, 1, 1'b1);
        bytes[0] = 8'h00; bytes[1] = 8'hFF; bytes[2] = 8'h3C;
        run_burst(3, 1'b0, 0, 1'b1);
        bytes[0] = 8'hA5;
        run_burst(1, 1'b0, 0, 1'b0);
        repeat (3) begin
            @(negedge clk);
            check(5'b11000, "R8");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule